// File: doc/BRIEF.md
# Segment Limit Protection Checker

This block decides whether one memory access falls inside the legal offset range of a loaded segment. A request carries the segment's 20-bit raw limit, its granularity, growth direction and big flags, an indication that the access goes through the stack segment, a 32-bit offset and an access size. One cycle later the block returns a response pulse. The pulse says whether the access is allowed and, if it is not, which fault class a processor pipeline should raise.

The raw limit is scaled into an effective limit. With granularity clear it counts bytes. With granularity set it counts 4 KiB pages, and the twelve low offset bits are filled with ones so they drop out of the compare. Expand-up segments accept offsets from zero up to the effective limit. Expand-down segments accept offsets strictly above the effective limit, up to a ceiling chosen by the big flag. Multi-byte accesses must fit entirely in the legal range. Privilege, type, paging and base addition are done elsewhere.

Top module: `seg_limit_chk`

## Requirements
- R1: A synchronous active-high reset clears `rsp_valid`, `rsp_ok` and `rsp_fault` (to 00) at the next clock edge.
- R2: Every cycle with `req_valid` high produces `rsp_valid` high on the following cycle. A cycle without a request produces `rsp_valid` low on the following cycle.
- R3: With `req_gran` = 0 the effective limit equals the raw limit, counted in bytes.
- R4: With `req_gran` = 1 the effective limit is the raw limit shifted left by 12 with the low 12 bits set. A raw limit of 0 therefore allows offsets 0 to 4095 in an expand-up segment.
- R5: In an expand-up segment (`req_down` = 0) the access is legal only when its last byte is at or below the effective limit.
- R6: In an expand-down segment (`req_down` = 1) the access faults when its first byte is at or below the effective limit.
- R7: In an expand-down segment the last byte must not exceed FFFFFFFFh when `req_big` = 1, or FFFFh when `req_big` = 0.
- R8: `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The last byte is offset + bytes − 1, and a carry out of bit 31 is a violation.
- R9: `rsp_fault` reads 00 for no fault, 01 for a general-protection fault, and 10 for a stack fault. A violation with `req_stack` = 1 reports 10, and any other violation reports 01. Code 11 never appears.
- R10: `rsp_ok` is high exactly when `rsp_valid` is high and `rsp_fault` is 00. When `rsp_valid` is low, `rsp_fault` is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_limit | input | 20 | Raw segment limit |
| req_gran | input | 1 | Limit counts 4 KiB pages when high |
| req_down | input | 1 | Segment grows downward when high |
| req_big | input | 1 | Expand-down ceiling is FFFFFFFFh when high, FFFFh when low |
| req_stack | input | 1 | Access goes through the stack segment |
| req_offset | input | 32 | Offset of the first byte |
| req_size | input | 2 | Access length code: 1, 2, 4 or 8 bytes |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 2 | Fault class: 00 none, 01 general protection, 10 stack |

## Verification
A wrong effective limit or span moves the legal window by a byte or by a page. It shows up as a flipped `rsp_ok` on the response pulse that follows the request, so the vectors sit on both sides of each boundary: the byte limit, the page fill, the expand-down floor and the two ceilings. A wrong fault-class choice shows in the same cycle as a swapped 01/10 code. A broken valid register shows one cycle after any request or idle cycle. Back-to-back requests show whether a response depends only on the request that made it.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   // Fault class reported on the response
   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_GP    = 2'b01,
      FLT_STACK = 2'b10
   } fault_e;

endpackage

// File: rtl/seg_limit_expand.sv
// Scales the raw limit into an effective byte limit, one bit wider than the offset.
module seg_limit_expand #(
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int EXT_W      = 33
) (
   input  logic [LIM_W-1:0] raw_limit,
   input  logic             gran,
   output logic [EXT_W-1:0] eff_limit
);

   generate
      if (GRAN_SHIFT < 1) begin : g_bad_shift
         $error("seg_limit_expand: GRAN_SHIFT must be at least 1");
      end
      if (LIM_W + GRAN_SHIFT >= EXT_W) begin : g_bad_width
         $error("seg_limit_expand: scaled limit does not fit below the carry bit");
      end
   endgenerate

   logic [GRAN_SHIFT-1:0] page_fill;
   logic [EXT_W-1:0]      byte_lim;
   logic [EXT_W-1:0]      page_lim;

   // One fill bit per ignored offset bit, each set only for page granularity
   for (genvar i = 0; i < GRAN_SHIFT; i++) begin : g_fill
      assign page_fill[i] = gran;
   end

   assign byte_lim  = EXT_W'(raw_limit);
   assign page_lim  = (EXT_W'(raw_limit) << GRAN_SHIFT) | EXT_W'(page_fill);
   assign eff_limit = gran ? page_lim : byte_lim;

endmodule

// File: rtl/seg_access_span.sv
// Extends the offset and computes the address of the last touched byte.
module seg_access_span #(
   parameter int OFS_W = 32,
   parameter int SZ_W  = 2,
   parameter int EXT_W = 33
) (
   input  logic [OFS_W-1:0] offset,
   input  logic [SZ_W-1:0]  size_code,
   output logic [EXT_W-1:0] first_byte,
   output logic [EXT_W-1:0] last_byte,
   output logic             span_carry
);

   localparam int SZ_CODES = 1 << SZ_W;

   generate
      if (EXT_W != OFS_W + 1) begin : g_bad_ext
         $error("seg_access_span: EXT_W must be OFS_W + 1");
      end
      if (SZ_CODES > OFS_W) begin : g_bad_size
         $error("seg_access_span: access length exceeds offset width");
      end
   endgenerate

   logic [EXT_W-1:0] len_minus1;

   always_comb begin
      len_minus1 = '0;
      for (int i = 0; i < SZ_CODES; i++) begin
         if (size_code == SZ_W'(i)) begin
            len_minus1 = (EXT_W'(1) << i) - EXT_W'(1);
         end
      end
   end

   assign first_byte = EXT_W'(offset);
   assign last_byte  = first_byte + len_minus1;
   assign span_carry = last_byte[EXT_W-1];

endmodule

// File: rtl/seg_bound_cmp.sv
// Compares an access span against the window allowed by the segment direction.
module seg_bound_cmp #(
   parameter int OFS_W   = 32,
   parameter int SMALL_W = 16,
   parameter int EXT_W   = 33
) (
   input  logic [EXT_W-1:0] eff_limit,
   input  logic [EXT_W-1:0] first_byte,
   input  logic [EXT_W-1:0] last_byte,
   input  logic             span_carry,
   input  logic             down,
   input  logic             big,
   output logic             violation
);

   generate
      if (SMALL_W >= OFS_W) begin : g_bad_small
         $error("seg_bound_cmp: SMALL_W must be narrower than OFS_W");
      end
   endgenerate

   localparam logic [EXT_W-1:0] CEIL_BIG   = EXT_W'({OFS_W{1'b1}});
   localparam logic [EXT_W-1:0] CEIL_SMALL = EXT_W'({SMALL_W{1'b1}});

   logic [EXT_W-1:0] ceiling;
   logic             up_viol;
   logic             down_floor;
   logic             down_ceil;

   assign ceiling    = big ? CEIL_BIG : CEIL_SMALL;
   assign up_viol    = span_carry | (last_byte > eff_limit);
   assign down_floor = first_byte <= eff_limit;
   assign down_ceil  = span_carry | (last_byte > ceiling);
   assign violation  = down ? (down_floor | down_ceil) : up_viol;

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int OFS_W      = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SMALL_W    = 16,
   parameter int SZ_W       = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [LIM_W-1:0] req_limit,
   input  logic             req_gran,
   input  logic             req_down,
   input  logic             req_big,
   input  logic             req_stack,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [SZ_W-1:0]  req_size,
   output logic             rsp_valid,
   output logic             rsp_ok,
   output logic [1:0]       rsp_fault
);
   import seg_chk_pkg::*;

   localparam int EXT_W = OFS_W + 1;

   generate
      if (LIM_W + GRAN_SHIFT > OFS_W) begin : g_bad_limit
         $error("seg_limit_chk: scaled limit wider than offset");
      end
   endgenerate

   logic [EXT_W-1:0] eff_limit;
   logic [EXT_W-1:0] first_byte;
   logic [EXT_W-1:0] last_byte;
   logic             span_carry;
   logic             violation;
   fault_e           fault_d;
   fault_e           fault_q;

   seg_limit_expand #(
      .LIM_W      (LIM_W),
      .GRAN_SHIFT (GRAN_SHIFT),
      .EXT_W      (EXT_W)
   ) u_expand (
      .raw_limit (req_limit),
      .gran      (req_gran),
      .eff_limit (eff_limit)
   );

   seg_access_span #(
      .OFS_W (OFS_W),
      .SZ_W  (SZ_W),
      .EXT_W (EXT_W)
   ) u_span (
      .offset     (req_offset),
      .size_code  (req_size),
      .first_byte (first_byte),
      .last_byte  (last_byte),
      .span_carry (span_carry)
   );

   seg_bound_cmp #(
      .OFS_W   (OFS_W),
      .SMALL_W (SMALL_W),
      .EXT_W   (EXT_W)
   ) u_cmp (
      .eff_limit  (eff_limit),
      .first_byte (first_byte),
      .last_byte  (last_byte),
      .span_carry (span_carry),
      .down       (req_down),
      .big        (req_big),
      .violation  (violation)
   );

   always_comb begin
      if (!violation)     fault_d = FLT_NONE;
      else if (req_stack) fault_d = FLT_STACK;
      else                fault_d = FLT_GP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         fault_q   <= FLT_NONE;
      end else if (req_valid) begin
         rsp_valid <= 1'b1;
         rsp_ok    <= !violation;
         fault_q   <= fault_d;
      end else begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         fault_q   <= FLT_NONE;
      end
   end

   assign rsp_fault = fault_q;

endmodule

// File: rtl/seg_limit_chk_sva.sv
module seg_limit_chk_sva #(
   parameter int OFS_W      = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SMALL_W    = 16,
   parameter int SZ_W       = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic [LIM_W-1:0] req_limit,
   input logic             req_gran,
   input logic             req_down,
   input logic             req_big,
   input logic             req_stack,
   input logic [OFS_W-1:0] req_offset,
   input logic [SZ_W-1:0]  req_size,
   input logic             rsp_valid,
   input logic             rsp_ok,
   input logic [1:0]       rsp_fault
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!rsp_valid && !rsp_ok && rsp_fault == 2'b00));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);

   assert_page0_ok_R4: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_gran && !req_down && req_size == '0
       && req_offset < OFS_W'(1 << GRAN_SHIFT)) |=> rsp_ok);

   assert_up_over_R5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_gran && !req_down && req_offset > OFS_W'(req_limit))
      |=> !rsp_ok);

   assert_down_floor_R6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_down && !req_gran && req_offset <= OFS_W'(req_limit))
      |=> !rsp_ok);

   assert_down_small_R7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_down && !req_big && (req_offset >> SMALL_W) != '0)
      |=> !rsp_ok);

   assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
      rsp_fault != 2'b11);

   assert_stack_class_R9: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_stack) |=> rsp_fault != 2'b01);

   assert_gp_class_R9: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_stack) |=> rsp_fault != 2'b10);

   assert_ok_match_R10: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_ok == (rsp_fault == 2'b00)));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> (!rsp_ok && rsp_fault == 2'b00));

endmodule

bind seg_limit_chk seg_limit_chk_sva #(
   .OFS_W      (OFS_W),
   .LIM_W      (LIM_W),
   .GRAN_SHIFT (GRAN_SHIFT),
   .SMALL_W    (SMALL_W),
   .SZ_W       (SZ_W)
) u_sva (.*);

// File: tb/seg_limit_chk_tb.sv
module seg_limit_chk_tb;

   typedef struct packed {
      logic        down;
      logic        big;
      logic        gran;
      logic        stk;
      logic [1:0]  sz;
      logic [19:0] lim;
      logic [31:0] off;
      logic [1:0]  exp;
      logic [3:0]  rq;   // requirement number for the message
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b0,1'b0,2'd0,20'h00FFF,32'h0000_0FFF,2'b00,4'd3},  // R3 at limit
      '{1'b0,1'b0,1'b0,1'b0,2'd0,20'h00FFF,32'h0000_1000,2'b01,4'd5},  // R5 one past
      '{1'b0,1'b0,1'b0,1'b1,2'd0,20'h00FFF,32'h0000_1000,2'b10,4'd9},  // R9 stack class
      '{1'b0,1'b0,1'b1,1'b0,2'd0,20'h00000,32'h0000_0FFF,2'b00,4'd4},  // R4 page 0 top
      '{1'b0,1'b0,1'b1,1'b0,2'd0,20'h00000,32'h0000_1000,2'b01,4'd4},  // R4 page 1
      '{1'b0,1'b0,1'b1,1'b0,2'd0,20'hFFFFF,32'hFFFF_FFFF,2'b00,4'd4},  // R4 full space
      '{1'b0,1'b0,1'b1,1'b0,2'd2,20'hFFFFF,32'hFFFF_FFFD,2'b01,4'd8},  // R8 carry
      '{1'b0,1'b0,1'b0,1'b0,2'd2,20'h00100,32'h0000_00FD,2'b00,4'd8},  // R8 last = limit
      '{1'b0,1'b0,1'b0,1'b0,2'd2,20'h00100,32'h0000_00FE,2'b01,4'd8},  // R8 last past
      '{1'b0,1'b0,1'b0,1'b0,2'd1,20'h00100,32'h0000_00FF,2'b00,4'd8},  // R8 two bytes
      '{1'b1,1'b1,1'b0,1'b0,2'd0,20'h00FFF,32'h0000_1000,2'b00,4'd6},  // R6 floor + 1
      '{1'b1,1'b1,1'b0,1'b0,2'd0,20'h00FFF,32'h0000_0FFF,2'b01,4'd6},  // R6 at floor
      '{1'b1,1'b1,1'b0,1'b1,2'd0,20'h00FFF,32'h0000_0000,2'b10,4'd9},  // R9 stack down
      '{1'b1,1'b0,1'b0,1'b0,2'd0,20'h00FFF,32'h0000_FFFF,2'b00,4'd7},  // R7 small ceiling
      '{1'b1,1'b0,1'b0,1'b1,2'd0,20'h00FFF,32'h0001_0000,2'b10,4'd7},  // R7 over small
      '{1'b1,1'b0,1'b0,1'b0,2'd1,20'h00FFF,32'h0000_FFFE,2'b00,4'd7},  // R7 span to ceiling
      '{1'b1,1'b0,1'b0,1'b0,2'd2,20'h00FFF,32'h0000_FFFE,2'b01,4'd7},  // R7 span over
      '{1'b1,1'b1,1'b1,1'b0,2'd0,20'h00001,32'h0000_1FFF,2'b01,4'd4},  // R4 page floor
      '{1'b1,1'b1,1'b1,1'b0,2'd0,20'h00001,32'h0000_2000,2'b00,4'd4},  // R4 above floor
      '{1'b1,1'b1,1'b0,1'b0,2'd3,20'h00FFF,32'hFFFF_FFF8,2'b00,4'd8},  // R8 eight to top
      '{1'b1,1'b1,1'b0,1'b0,2'd3,20'h00FFF,32'hFFFF_FFF9,2'b01,4'd8},  // R8 eight carry
      '{1'b1,1'b0,1'b1,1'b0,2'd0,20'h0000F,32'h0000_FFFF,2'b01,4'd7}   // R7 empty window
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [19:0] req_limit = '0;
   logic        req_gran = 1'b0;
   logic        req_down = 1'b0;
   logic        req_big = 1'b0;
   logic        req_stack = 1'b0;
   logic [31:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic        rsp_valid;
   logic        rsp_ok;
   logic [1:0]  rsp_fault;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   seg_limit_chk u_dut (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_limit  (req_limit),
      .req_gran   (req_gran),
      .req_down   (req_down),
      .req_big    (req_big),
      .req_stack  (req_stack),
      .req_offset (req_offset),
      .req_size   (req_size),
      .rsp_valid  (rsp_valid),
      .rsp_ok     (rsp_ok),
      .rsp_fault  (rsp_fault)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      req_valid  = 1'b1;
      req_down   = v.down;
      req_big    = v.big;
      req_gran   = v.gran;
      req_stack  = v.stk;
      req_size   = v.sz;
      req_limit  = v.lim;
      req_offset = v.off;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", 32'(rsp_valid), 32'd0);
      chk("R1 fault", 32'(rsp_fault), 32'd0);
      chk("R1 ok",    32'(rsp_ok),    32'd0);
      rst = 1'b0;
      @(negedge clk);

      // Vector table, requests back to back
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i]);
         @(negedge clk);
         chk($sformatf("R2 vec %0d valid", i), 32'(rsp_valid), 32'd1);
         chk($sformatf("R%0d vec %0d fault", TBL[i].rq, i), 32'(rsp_fault), 32'(TBL[i].exp));
         chk($sformatf("R10 vec %0d ok", i), 32'(rsp_ok), 32'(TBL[i].exp == 2'b00));
      end

      // R2, R10: idle cycle after a faulting request
      drive(TBL[1]);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle valid", 32'(rsp_valid), 32'd0);
      chk("R10 idle fault", 32'(rsp_fault), 32'd0);
      chk("R10 idle ok", 32'(rsp_ok), 32'd0);

      // R5: last legal byte then first illegal byte of a byte-granular segment
      drive('{1'b0,1'b0,1'b0,1'b0,2'd0,20'h12345,32'h0001_2345,2'b00,4'd5});
      @(negedge clk);
      chk("R5 at limit", 32'(rsp_fault), 32'd0);
      req_offset = 32'h0001_2346;
      @(negedge clk);
      chk("R5 past limit", 32'(rsp_fault), 32'd1);

      // R1: reset while a request is presented
      drive(TBL[2]);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid valid", 32'(rsp_valid), 32'd0);
      chk("R1 mid fault", 32'(rsp_fault), 32'd0);
      rst = 1'b0;
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 after reset", 32'(rsp_valid), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule